// File: doc/BRIEF.md
# ATA Channel Bring-Up Sequencer

This block brings a parallel ATA channel out of power-up in polled PIO mode, with no processor time spent on it. After a start strobe it first probes for an attached drive: it writes a drive-select byte for drive 0 and reads it back, and then does the same for drive 1 if drive 0 does not answer. If either drive answers, it pulses the channel's software-reset bit through the device control register. It then polls the status register until the drive reports itself idle and ready, or until the poll budget runs out.

The host side has a single start input and three results: a one-cycle completion pulse, a presence flag and a ready flag. The device side is a plain byte-wide register port with an address, write data, read data, a write strobe and a read strobe. Every settling delay, the reset hold time, the poll spacing and the poll budget are parameters counted in clock cycles. The defaults follow real drive timing, and a testbench can shrink them.

Top module: `ata_bringup_seq`

## Requirements
- R1: After reset, and until a start is accepted, `seqDone`, `devPresent` and `devReady` are 0 and neither bus strobe is asserted.
- R2: The probe writes the byte 0xA0 OR (drive index << 4) to register address 6 (drive select). It tries drive 0 (0xA0) first and drive 1 (0xB0) second, and reads the same address back after each write.
- R3: The probe write to address 6 is preceded by a wait of `PROBE_SETTLE` cycles. Its read-back strobe comes exactly `PROBE_SETTLE`+1 cycles after the write strobe. The drive 1 write comes `PROBE_SETTLE`+2 cycles after the failed drive 0 read.
- R4: A drive counts as present only when the byte read back in the cycle after the read strobe equals the byte just written. `devPresent` is then 1 when `seqDone` pulses.
- R5: When only drive 1 answers, the block writes 0x00 to address 6 before any reset write.
- R6: When neither drive answers, `devPresent` and `devReady` end at 0. No write to address 14 and no read of address 7 takes place.
- R7: The reset writes 0x06 to address 14 (device control: interrupt disabled, reset asserted). Exactly `RST_HOLD`+1 cycles later it writes 0x02 (interrupt disabled, reset released).
- R8: The first status read (address 7) comes `RST_SETTLE`+`POLL_GAP`+1 cycles after the 0x02 write. Consecutive status reads are `POLL_GAP`+2 cycles apart.
- R9: `devReady` becomes 1 only when a single status read shows bit 7 (busy) = 0 and bit 6 (drive ready) = 1. Polling stops after that read. Other bits, such as bit 3, are ignored.
- R10: At most `POLL_LIMIT` status reads are made in one run. If none succeeds, the run ends with `devReady` = 0 and `devPresent` = 1.
- R11: `seqDone` is high for exactly one cycle, two cycles after the last read strobe of the run. `devPresent` and `devReady` are valid from that cycle and held until the next start is accepted, which clears both.
- R12: A start pulse during a run has no effect: the run produces one completion and the same bus accesses as without that pulse.
- R13: Every read strobe lasts one cycle, and a read strobe and a write strobe are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Starts a bring-up run when the block is idle |
| busRdData | input | 8 | Register read data, valid the cycle after `busRdEn` |
| busAddr | output | 4 | Register address (6 drive select, 7 status, 14 device control) |
| busWrData | output | 8 | Register write data |
| busWrEn | output | 1 | One-cycle register write strobe |
| busRdEn | output | 1 | One-cycle register read strobe |
| seqDone | output | 1 | One-cycle completion pulse |
| devPresent | output | 1 | A drive answered the select probe |
| devReady | output | 1 | The drive reported idle and ready within the poll budget |

## Verification
The assertions check on every cycle the rules that hold in any single cycle or pair of cycles. These are single-cycle read strobes, write and read never together, the allowed select and control byte values, a one-cycle completion pulse, ready only when present, ready rising only after a status byte with busy clear and drive-ready set, and the poll count staying inside its budget. Only the directed scenarios can show the ordering and spacing of whole access sequences and the outcome of each answer pattern. These cover which drive answers, the extra reselect write, skipping the reset when nothing answers, exhaustion of the budget, and the rejection of busy and ready seen on different reads.

// File: rtl/ata_bringup_pkg.sv
package ata_bringup_pkg;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_DEVSEL = 4'd6;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'd7;
  localparam logic [ADDR_W-1:0] ADDR_DEVCTL = 4'd14;

  localparam logic [DATA_W-1:0] SEL_BASE    = 8'hA0;
  localparam logic [DATA_W-1:0] CTL_RST_ON  = 8'h06;
  localparam logic [DATA_W-1:0] CTL_RST_OFF = 8'h02;

  localparam int BSY_BIT  = 7;
  localparam int DRDY_BIT = 6;

  typedef enum logic [1:0] {
    DLY_PROBE,
    DLY_HOLD,
    DLY_SETTLE,
    DLY_GAP
  } dlyKind_e;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_WR_SEL,
    ACC_WR_ZERO,
    ACC_WR_RSTON,
    ACC_WR_RSTOFF,
    ACC_RD_SEL,
    ACC_RD_STAT
  } access_e;

  typedef struct packed {
    access_e  access;
    logic     dlyLoad;
    dlyKind_e dlyKind;
    logic     idxSet;
    logic     pollClr;
    logic     pollInc;
    logic     flagsClr;
    logic     presentSet;
    logic     readySet;
  } seqCmd_t;

endpackage

// File: rtl/ata_bringup_dp.sv
module ata_bringup_dp
  import ata_bringup_pkg::*;
#(
  parameter int PROBE_SETTLE = 2500000,
  parameter int RST_HOLD     = 250000,
  parameter int RST_SETTLE   = 2500000,
  parameter int POLL_GAP     = 5000000,
  parameter int POLL_LIMIT   = 300
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic [DATA_W-1:0] busRdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  output logic              busWrEn,
  output logic              busRdEn,
  output logic              dlyDone,
  output logic              selMatch,
  output logic              idxIsOne,
  output logic              statusOk,
  output logic              pollLast,
  output logic              devPresent,
  output logic              devReady
);

  localparam int MAX_A   = (PROBE_SETTLE > RST_HOLD) ? PROBE_SETTLE : RST_HOLD;
  localparam int MAX_B   = (RST_SETTLE > POLL_GAP) ? RST_SETTLE : POLL_GAP;
  localparam int MAX_DLY = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int DLY_W   = $clog2(MAX_DLY + 1);
  localparam int POLL_W  = $clog2(POLL_LIMIT + 1);

  logic [DLY_W-1:0]  dlyCnt;
  logic [DLY_W-1:0]  dlyInit;
  logic [POLL_W-1:0] pollCnt;
  logic              probeIdx;
  logic [DATA_W-1:0] selByte;

  // Wait length per kind; the counter runs from N-1 down to 0, giving N wait cycles.
  always_comb begin
    case (cmd.dlyKind)
      DLY_PROBE:  dlyInit = DLY_W'(PROBE_SETTLE - 1);
      DLY_HOLD:   dlyInit = DLY_W'(RST_HOLD - 1);
      DLY_SETTLE: dlyInit = DLY_W'(RST_SETTLE - 1);
      default:    dlyInit = DLY_W'(POLL_GAP - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dlyCnt <= '0;
    end else if (cmd.dlyLoad) begin
      dlyCnt <= dlyInit;
    end else if (dlyCnt != '0) begin
      dlyCnt <= dlyCnt - 1'b1;
    end
  end

  assign dlyDone = (dlyCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      probeIdx <= 1'b0;
    end else if (cmd.flagsClr) begin
      probeIdx <= 1'b0;
    end else if (cmd.idxSet) begin
      probeIdx <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollCnt <= '0;
    end else if (cmd.pollClr) begin
      pollCnt <= '0;
    end else if (cmd.pollInc) begin
      pollCnt <= pollCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devPresent <= 1'b0;
      devReady   <= 1'b0;
    end else if (cmd.flagsClr) begin
      devPresent <= 1'b0;
      devReady   <= 1'b0;
    end else begin
      if (cmd.presentSet) devPresent <= 1'b1;
      if (cmd.readySet)   devReady   <= 1'b1;
    end
  end

  assign selByte  = SEL_BASE | {3'b000, probeIdx, 4'b0000};
  assign idxIsOne = probeIdx;
  assign selMatch = (busRdData == selByte);
  assign statusOk = !busRdData[BSY_BIT] && busRdData[DRDY_BIT];
  assign pollLast = (pollCnt == POLL_W'(POLL_LIMIT - 1));

  always_comb begin
    busAddr   = '0;
    busWrData = '0;
    busWrEn   = 1'b0;
    busRdEn   = 1'b0;
    case (cmd.access)
      ACC_WR_SEL: begin
        busAddr   = ADDR_DEVSEL;
        busWrData = selByte;
        busWrEn   = 1'b1;
      end
      ACC_WR_ZERO: begin
        busAddr   = ADDR_DEVSEL;
        busWrEn   = 1'b1;
      end
      ACC_WR_RSTON: begin
        busAddr   = ADDR_DEVCTL;
        busWrData = CTL_RST_ON;
        busWrEn   = 1'b1;
      end
      ACC_WR_RSTOFF: begin
        busAddr   = ADDR_DEVCTL;
        busWrData = CTL_RST_OFF;
        busWrEn   = 1'b1;
      end
      ACC_RD_SEL: begin
        busAddr   = ADDR_DEVSEL;
        busRdEn   = 1'b1;
      end
      ACC_RD_STAT: begin
        busAddr   = ADDR_STATUS;
        busRdEn   = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ata_bringup_ctrl.sv
module ata_bringup_ctrl
  import ata_bringup_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startPulse,
  input  logic    dlyDone,
  input  logic    selMatch,
  input  logic    idxIsOne,
  input  logic    statusOk,
  input  logic    pollLast,
  output seqCmd_t cmd,
  output logic    seqDone
);

  typedef enum logic [3:0] {
    S_IDLE, S_PR_PRE, S_PR_WR, S_PR_MID, S_PR_RD, S_PR_CMP, S_RESEL,
    S_RST_ON, S_RST_HOLD, S_RST_OFF, S_RST_SET, S_POLL_GAP, S_POLL_RD,
    S_POLL_CMP, S_DONE
  } state_e;

  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt         = state;
    cmd         = '0;
    cmd.access  = ACC_NONE;
    cmd.dlyKind = DLY_PROBE;
    case (state)
      S_IDLE: if (startPulse) begin
        cmd.flagsClr = 1'b1;
        cmd.dlyLoad  = 1'b1;
        nxt          = S_PR_PRE;
      end
      S_PR_PRE: if (dlyDone) nxt = S_PR_WR;
      S_PR_WR: begin
        cmd.access  = ACC_WR_SEL;
        cmd.dlyLoad = 1'b1;
        nxt         = S_PR_MID;
      end
      S_PR_MID: if (dlyDone) nxt = S_PR_RD;
      S_PR_RD: begin
        cmd.access = ACC_RD_SEL;
        nxt        = S_PR_CMP;
      end
      S_PR_CMP: begin
        if (selMatch) begin
          cmd.presentSet = 1'b1;
          nxt = idxIsOne ? S_RESEL : S_RST_ON;
        end else if (!idxIsOne) begin
          cmd.idxSet  = 1'b1;
          cmd.dlyLoad = 1'b1;
          nxt         = S_PR_PRE;
        end else begin
          nxt = S_DONE;
        end
      end
      S_RESEL: begin
        cmd.access = ACC_WR_ZERO;
        nxt        = S_RST_ON;
      end
      S_RST_ON: begin
        cmd.access  = ACC_WR_RSTON;
        cmd.dlyLoad = 1'b1;
        cmd.dlyKind = DLY_HOLD;
        nxt         = S_RST_HOLD;
      end
      S_RST_HOLD: if (dlyDone) nxt = S_RST_OFF;
      S_RST_OFF: begin
        cmd.access  = ACC_WR_RSTOFF;
        cmd.dlyLoad = 1'b1;
        cmd.dlyKind = DLY_SETTLE;
        cmd.pollClr = 1'b1;
        nxt         = S_RST_SET;
      end
      S_RST_SET: if (dlyDone) begin
        cmd.dlyLoad = 1'b1;
        cmd.dlyKind = DLY_GAP;
        nxt         = S_POLL_GAP;
      end
      S_POLL_GAP: if (dlyDone) nxt = S_POLL_RD;
      S_POLL_RD: begin
        cmd.access = ACC_RD_STAT;
        nxt        = S_POLL_CMP;
      end
      S_POLL_CMP: begin
        if (statusOk) begin
          cmd.readySet = 1'b1;
          nxt          = S_DONE;
        end else if (pollLast) begin
          nxt = S_DONE;
        end else begin
          cmd.pollInc = 1'b1;
          cmd.dlyLoad = 1'b1;
          cmd.dlyKind = DLY_GAP;
          nxt         = S_POLL_GAP;
        end
      end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign seqDone = (state == S_DONE);

endmodule

// File: rtl/ata_bringup_seq.sv
module ata_bringup_seq
  import ata_bringup_pkg::*;
#(
  parameter int PROBE_SETTLE = 2500000,
  parameter int RST_HOLD     = 250000,
  parameter int RST_SETTLE   = 2500000,
  parameter int POLL_GAP     = 5000000,
  parameter int POLL_LIMIT   = 300
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic [7:0] busRdData,
  output logic [3:0] busAddr,
  output logic [7:0] busWrData,
  output logic       busWrEn,
  output logic       busRdEn,
  output logic       seqDone,
  output logic       devPresent,
  output logic       devReady
);

  seqCmd_t cmd;
  logic dlyDone, selMatch, idxIsOne, statusOk, pollLast;

  ata_bringup_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .dlyDone    (dlyDone),
    .selMatch   (selMatch),
    .idxIsOne   (idxIsOne),
    .statusOk   (statusOk),
    .pollLast   (pollLast),
    .cmd        (cmd),
    .seqDone    (seqDone)
  );

  ata_bringup_dp #(
    .PROBE_SETTLE (PROBE_SETTLE),
    .RST_HOLD     (RST_HOLD),
    .RST_SETTLE   (RST_SETTLE),
    .POLL_GAP     (POLL_GAP),
    .POLL_LIMIT   (POLL_LIMIT)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .busRdData  (busRdData),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .dlyDone    (dlyDone),
    .selMatch   (selMatch),
    .idxIsOne   (idxIsOne),
    .statusOk   (statusOk),
    .pollLast   (pollLast),
    .devPresent (devPresent),
    .devReady   (devReady)
  );

endmodule

// File: rtl/ata_bringup_chk.sv
module ata_bringup_chk #(
  parameter int POLL_LIMIT = 300
) (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] busRdData,
  input logic [3:0] busAddr,
  input logic [7:0] busWrData,
  input logic       busWrEn,
  input logic       busRdEn,
  input logic       seqDone,
  input logic       devPresent,
  input logic       devReady
);

  localparam int CW = $clog2(POLL_LIMIT + 2) + 1;
  logic [CW-1:0] statReads;

  always_ff @(posedge clk) begin
    if (!rstN || seqDone) statReads <= '0;
    else if (busRdEn && busAddr == 4'd7) statReads <= statReads + 1'b1;
  end

  p_rd_single_r13: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> !busRdEn);

  p_no_overlap_r13: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busRdEn));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);

  p_ready_needs_present_r9: assert property (@(posedge clk) disable iff (!rstN)
    devReady |-> devPresent);

  p_ctl_values_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 4'd14) |-> (busWrData == 8'h06 || busWrData == 8'h02));

  p_sel_values_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 4'd6) |-> (busWrData == 8'hA0 || busWrData == 8'hB0 || busWrData == 8'h00));

  p_ready_status_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devReady) |-> (!$past(busRdData[7]) && $past(busRdData[6])));

  p_budget_r10: assert property (@(posedge clk) disable iff (!rstN)
    statReads <= CW'(POLL_LIMIT));

endmodule

bind ata_bringup_seq ata_bringup_chk #(.POLL_LIMIT(POLL_LIMIT)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busRdData  (busRdData),
  .busAddr    (busAddr),
  .busWrData  (busWrData),
  .busWrEn    (busWrEn),
  .busRdEn    (busRdEn),
  .seqDone    (seqDone),
  .devPresent (devPresent),
  .devReady   (devReady)
);

// File: tb/test_ata_bringup_seq.sv
`timescale 1ns/1ps
module test_ata_bringup_seq;

  localparam int PS = 4;
  localparam int RH = 3;
  localparam int RS = 5;
  localparam int PG = 2;
  localparam int PL = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic [7:0] busRdData;
  logic [3:0] busAddr;
  logic [7:0] busWrData;
  logic       busWrEn, busRdEn, seqDone, devPresent, devReady;

  always #10 clk = ~clk;

  ata_bringup_seq #(
    .PROBE_SETTLE (PS), .RST_HOLD (RH), .RST_SETTLE (RS),
    .POLL_GAP (PG), .POLL_LIMIT (PL)
  ) i_ata_bringup_seq (
    .clk (clk), .rstN (rstN), .startPulse (startPulse), .busRdData (busRdData),
    .busAddr (busAddr), .busWrData (busWrData), .busWrEn (busWrEn),
    .busRdEn (busRdEn), .seqDone (seqDone), .devPresent (devPresent),
    .devReady (devReady)
  );

  // Device model and access log
  logic       resp0 = 1'b1, resp1 = 1'b0;
  logic [7:0] statSeq [8];
  logic       logClear = 1'b0;
  logic [7:0] devReg = 8'hFF, rdData = 8'hFF;
  int cyc = 0, nWr = 0, nRd = 0, pollNum = 0, doneCnt = 0, doneCyc = 0;
  int wrAddr [64], wrData [64], wrCyc [64], rdAddr [64], rdCyc [64];
  int nChecks = 0, nFail = 0;

  assign busRdData = rdData;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (logClear) begin
      nWr <= 0; nRd <= 0; pollNum <= 0; doneCnt <= 0; devReg <= 8'hFF;
    end else begin
      if (busWrEn && nWr < 64) begin
        wrAddr[nWr] <= int'(busAddr); wrData[nWr] <= int'(busWrData);
        wrCyc[nWr] <= cyc; nWr <= nWr + 1;
        if (busAddr == 4'd6) begin
          if ((busWrData == 8'hA0 && resp0) || (busWrData == 8'hB0 && resp1)) devReg <= busWrData;
          else if (busWrData == 8'h00) devReg <= 8'h00;
          else devReg <= 8'hFF;
        end
      end
      if (busRdEn && nRd < 64) begin
        rdAddr[nRd] <= int'(busAddr); rdCyc[nRd] <= cyc; nRd <= nRd + 1;
        if (busAddr == 4'd6) rdData <= devReg;
        else if (busAddr == 4'd7) begin
          rdData  <= statSeq[(pollNum > 7) ? 7 : pollNum];
          pollNum <= pollNum + 1;
        end else rdData <= 8'hFF;
      end
      if (seqDone) begin
        doneCnt <= doneCnt + 1; doneCyc <= cyc;
      end
    end
  end

  task automatic chkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic setStat(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input logic [7:0] rest);
    statSeq[0] = a; statSeq[1] = b; statSeq[2] = c;
    for (int i = 3; i < 8; i++) statSeq[i] = rest;
  endtask

  task automatic clearLog();
    @(negedge clk); logClear = 1'b1;
    @(negedge clk); logClear = 1'b0;
  endtask

  task automatic runSeq();
    int waited;
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    waited = 0;
    while (doneCnt == 0 && waited < 5000) begin
      @(negedge clk); waited++;
    end
    chkEq("R11 completion seen", (doneCnt > 0) ? 1 : 0, 1);
    repeat (10) @(negedge clk);
  endtask

  task automatic testReset();
    int strobes = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busWrEn || busRdEn) strobes++;
    end
    chkEq("R1 no strobes while idle", strobes, 0);
    chkEq("R1 done low", int'(seqDone), 0);
    chkEq("R1 present low", int'(devPresent), 0);
    chkEq("R1 ready low", int'(devReady), 0);
  endtask

  task automatic testDrive0();
    resp0 = 1; resp1 = 0; setStat(8'h80, 8'h80, 8'h50, 8'h50);
    clearLog(); runSeq();
    chkEq("R4 present", int'(devPresent), 1);
    chkEq("R9 ready", int'(devReady), 1);
    chkEq("R2 write count", nWr, 3);
    chkEq("R2 probe addr", wrAddr[0], 6);
    chkEq("R2 probe byte", wrData[0], 'hA0);
    chkEq("R2 readback addr", rdAddr[0], 6);
    chkEq("R3 write to read spacing", rdCyc[0] - wrCyc[0], PS + 1);
    chkEq("R7 assert addr", wrAddr[1], 14);
    chkEq("R7 assert byte", wrData[1], 6);
    chkEq("R7 release byte", wrData[2], 2);
    chkEq("R7 hold spacing", wrCyc[2] - wrCyc[1], RH + 1);
    chkEq("R9 stops at good read", nRd, 4);
    chkEq("R8 status addr", rdAddr[1], 7);
    chkEq("R8 first poll", rdCyc[1] - wrCyc[2], RS + PG + 1);
    chkEq("R8 poll spacing", rdCyc[2] - rdCyc[1], PG + 2);
    chkEq("R11 done timing", doneCyc - rdCyc[3], 2);
    chkEq("R11 done count", doneCnt, 1);
  endtask

  task automatic testDrive1();
    resp0 = 0; resp1 = 1; setStat(8'h50, 8'h50, 8'h50, 8'h50);
    clearLog(); runSeq();
    chkEq("R4 present drive1", int'(devPresent), 1);
    chkEq("R9 ready drive1", int'(devReady), 1);
    chkEq("R5 write count", nWr, 5);
    chkEq("R2 second probe byte", wrData[1], 'hB0);
    chkEq("R3 second probe spacing", wrCyc[1] - rdCyc[0], PS + 2);
    chkEq("R5 reselect addr", wrAddr[2], 6);
    chkEq("R5 reselect byte", wrData[2], 0);
    chkEq("R5 reset after reselect", wrData[3], 6);
    chkEq("R9 one status read", nRd, 3);
  endtask

  task automatic testNone();
    int wr14 = 0, rd7 = 0;
    resp0 = 0; resp1 = 0;
    clearLog();
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    chkEq("R11 present cleared at start", int'(devPresent), 0);
    chkEq("R11 ready cleared at start", int'(devReady), 0);
    for (int i = 0; i < 200 && doneCnt == 0; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    for (int i = 0; i < nWr; i++) if (wrAddr[i] == 14) wr14++;
    for (int i = 0; i < nRd; i++) if (rdAddr[i] == 7) rd7++;
    chkEq("R6 not present", int'(devPresent), 0);
    chkEq("R6 not ready", int'(devReady), 0);
    chkEq("R6 no control writes", wr14, 0);
    chkEq("R6 no status reads", rd7, 0);
    chkEq("R6 two probes", nWr, 2);
    chkEq("R11 done timing none", doneCyc - rdCyc[1], 2);
  endtask

  task automatic testTimeout();
    resp0 = 1; resp1 = 1; setStat(8'hC0, 8'hC0, 8'hC0, 8'hC0);
    clearLog(); runSeq();
    chkEq("R10 present kept", int'(devPresent), 1);
    chkEq("R10 not ready", int'(devReady), 0);
    chkEq("R10 read budget", nRd, 1 + PL);
    chkEq("R11 done after last poll", doneCyc - rdCyc[PL], 2);
  endtask

  task automatic testSplitBits();
    resp0 = 1; resp1 = 0; setStat(8'h00, 8'hC0, 8'h48, 8'h48);
    clearLog(); runSeq();
    chkEq("R9 ready on same-read bits", int'(devReady), 1);
    chkEq("R9 split bits rejected", nRd, 4);
  endtask

  task automatic testRestartIgnored();
    resp0 = 1; resp1 = 0; setStat(8'h50, 8'h50, 8'h50, 8'h50);
    clearLog();
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    repeat (8) @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    repeat (12) @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    for (int i = 0; i < 200 && doneCnt == 0; i++) @(negedge clk);
    repeat (40) @(negedge clk);
    chkEq("R12 single completion", doneCnt, 1);
    chkEq("R12 write count", nWr, 3);
    chkEq("R12 read count", nRd, 2);
    chkEq("R11 ready held", int'(devReady), 1);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    setStat(8'h50, 8'h50, 8'h50, 8'h50);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDrive0();
    testDrive1();
    testNone();
    testTimeout();
    testSplitBits();
    testRestartIgnored();
    finishRun();
  end

endmodule